// File: doc/BRIEF.md
# MSI Vector Block Allocator

This block keeps a small table of message-signalled interrupt grants, one entry per requesting device. Each entry holds the device's configuration address, the number of vectors it was granted and the first global interrupt number of its block. Requests come in one at a time over a valid/ready handshake. Each request gets exactly one response pulse that carries a status code and the result fields.

A change request with a nonzero count does one of two things. If the device has no entry yet, it takes a new entry and a contiguous run of interrupt numbers from an internal linear pool. If the device already has an entry with the same count, it reuses that entry. A change request with a count of zero is a release. A release only confirms that the entry exists, because entries are never freed. A query turns a device-relative vector number into a global interrupt source number. For a granted change, the block returns the message base address that the device would be programmed with: the window base with the entry index placed at bit 16. The per-vector MSI-X offset of four bytes per vector is applied downstream.

The controller has four states. IDLE accepts a request. From IDLE, a change with an unknown function code goes straight to FINISH, and every other request goes to SCAN. SCAN reads one entry per cycle, starting at index 0. It leaves for FINISH on a configuration match, on the first empty entry, or after the last entry. FINISH decides the result, updates the table and the pool, and registers the response. It always moves to RESP. RESP holds the response pulse for one cycle and returns to IDLE.

Top module: `msi_vec_alloc`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. `req_ready` is 1 only in IDLE. Each accepted request produces exactly one `rsp_valid` pulse, one cycle long, and `req_ready` is 0 during that pulse.
- R2: Status is a 4-bit two's-complement code: 4'h0 means ok, 4'hF (-1) means hardware error, 4'hD (-3) means parameter error. For a change request, function codes 1 and 3 return type 1 (MSI) and code 4 returns type 2 (MSI-X). Any other function code returns 4'hD and leaves the table unchanged.
- R3: A change with a nonzero count for a configuration address that has no entry takes the first empty entry. It returns status 0, the requested count, `req_seq`+1 modulo 2^SEQ_W, and the type.
- R4: A change with the same address and the same count as an existing entry returns status 0. It keeps the stored base interrupt number and takes nothing from the pool.
- R5: A change with a nonzero count that differs from an existing entry's count returns 4'hF and leaves the entry unchanged.
- R6: A release (count 0) returns status 0 with count 0 when the entry exists, and 4'hF when it does not. In both cases the table is unchanged.
- R7: The message address of a granted change is WIN_BASE OR (entry index << 16). Entry indices are given out in allocation order, starting at 0.
- R8: A query for an existing entry returns status 0, the entry's base interrupt number plus `req_vec`, and `rsp_edge`=1. A query with no entry returns 4'hF with `rsp_edge`=0.
- R9: Base numbers are handed out contiguously from IRQ_FIRST. A request that would exceed POOL_SIZE vectors in total returns 4'hF and creates no entry.
- R10: Once all DEPTH entries are used, a change for a new address returns 4'hF. Existing entries remain reachable.
- R11: The response appears at most DEPTH+3 cycles after the request is accepted, because the scan takes one cycle per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_query | input | 1 | 1 = query, 0 = change/release |
| req_func | input | 4 | Change function code |
| req_cfg | input | CFG_W | Device configuration address |
| req_count | input | CNT_W | Requested vector count (0 = release) |
| req_seq | input | SEQ_W | Caller sequence number |
| req_vec | input | CNT_W | Device-relative vector for a query |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 4 | Status code |
| rsp_count | output | CNT_W | Granted vector count |
| rsp_seq | output | SEQ_W | Incremented sequence number |
| rsp_type | output | 2 | Interrupt type (1 MSI, 2 MSI-X) |
| rsp_msg_addr | output | ADDR_W | Message base address |
| rsp_irq | output | IRQ_W | Global interrupt source number |
| rsp_edge | output | 1 | 1 = edge-triggered source |

## Verification
The bench targets reuse with a changed count. A design that overwrote the entry would accept the request, and a later query would then return moved interrupt numbers. It checks that a pool request exceeding the remainder by one vector is refused. A design that still took the entry would shift the index of the next device's message address, and an off-by-one fit test would show up at exactly this boundary. It wraps the sequence number at its maximum value and confirms that releases and refused requests leave earlier grants intact. It fills every entry and then reuses the last one, which exercises the longest scan and the check for a full table.

// File: rtl/msi_alloc_pkg.sv
package msi_alloc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FINISH,
        ST_RESP
    } alloc_state_t;

    localparam logic [3:0] STS_OK        = 4'h0;
    localparam logic [3:0] STS_HW_ERR    = 4'hF;
    localparam logic [3:0] STS_PARAM_ERR = 4'hD;

    localparam logic [3:0] FN_CHANGE = 4'd1;
    localparam logic [3:0] FN_MSI    = 4'd3;
    localparam logic [3:0] FN_MSIX   = 4'd4;

    localparam logic [1:0] TYPE_MSI  = 2'd1;
    localparam logic [1:0] TYPE_MSIX = 2'd2;

    function automatic logic func_known(input logic [3:0] f);
        return (f == FN_CHANGE) || (f == FN_MSI) || (f == FN_MSIX);
    endfunction

endpackage

// File: rtl/msi_entry_table.sv
module msi_entry_table #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CFG_W = 16,
    parameter int CNT_W = 6,
    parameter int IRQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CFG_W-1:0] rd_cfg,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [IRQ_W-1:0] rd_base,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CFG_W-1:0] wr_cfg,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [IRQ_W-1:0] wr_base
);
    logic [CFG_W-1:0] cfg_a  [DEPTH];
    logic [CNT_W-1:0] cnt_a  [DEPTH];
    logic [IRQ_W-1:0] base_a [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_a[e]  <= '0;
                cnt_a[e]  <= '0;
                base_a[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                cfg_a[e]  <= wr_cfg;
                cnt_a[e]  <= wr_cnt;
                base_a[e] <= wr_base;
            end
        end
    end

    assign rd_cfg  = cfg_a[rd_idx];
    assign rd_cnt  = cnt_a[rd_idx];
    assign rd_base = base_a[rd_idx];

endmodule

// File: rtl/msi_irq_pool.sv
module msi_irq_pool #(
    parameter int IRQ_W     = 12,
    parameter int CNT_W     = 6,
    parameter int IRQ_FIRST = 256,
    parameter int POOL_SIZE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ask_n,
    input  logic             take,
    output logic             fits,
    output logic [IRQ_W-1:0] next_base
);
    localparam int UW = $clog2(POOL_SIZE + 1);
    localparam int SW = UW + CNT_W;

    logic [UW-1:0] used_q;
    logic [SW-1:0] sum;

    assign sum       = SW'(used_q) + SW'(ask_n);
    assign fits      = (sum <= SW'(POOL_SIZE));
    assign next_base = IRQ_W'(IRQ_FIRST) + IRQ_W'(used_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (take && fits) begin
            used_q <= UW'(sum);
        end
    end

endmodule

// File: rtl/msi_vec_alloc.sv
module msi_vec_alloc
    import msi_alloc_pkg::*;
#(
    parameter int              DEPTH     = 8,
    parameter int              CFG_W     = 16,
    parameter int              CNT_W     = 6,
    parameter int              SEQ_W     = 8,
    parameter int              IRQ_W     = 12,
    parameter int              IRQ_FIRST = 256,
    parameter int              POOL_SIZE = 64,
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_query,
    input  logic [3:0]        req_func,
    input  logic [CFG_W-1:0]  req_cfg,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [SEQ_W-1:0]  req_seq,
    input  logic [CNT_W-1:0]  req_vec,
    output logic              rsp_valid,
    output logic [3:0]        rsp_status,
    output logic [CNT_W-1:0]  rsp_count,
    output logic [SEQ_W-1:0]  rsp_seq,
    output logic [1:0]        rsp_type,
    output logic [ADDR_W-1:0] rsp_msg_addr,
    output logic [IRQ_W-1:0]  rsp_irq,
    output logic              rsp_edge
);
    localparam int               IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    alloc_state_t state_q, state_d;

    logic             query_q, bad_func_q, hit_q, empty_q;
    logic [3:0]       func_q;
    logic [CFG_W-1:0] cfg_q;
    logic [CNT_W-1:0] count_q, vec_q;
    logic [SEQ_W-1:0] seq_q;
    logic [IDX_W-1:0] scan_idx;

    logic [CFG_W-1:0] ent_cfg;
    logic [CNT_W-1:0] ent_cnt;
    logic [IRQ_W-1:0] ent_base;
    logic             pool_fits;
    logic [IRQ_W-1:0] pool_base;

    logic              accept;
    logic              fin_alloc, fin_write;
    logic [3:0]        fin_status;
    logic [CNT_W-1:0]  fin_count;
    logic [SEQ_W-1:0]  fin_seq;
    logic [1:0]        fin_type;
    logic [ADDR_W-1:0] fin_addr;
    logic [IRQ_W-1:0]  fin_irq;
    logic              fin_edge;

    assign accept    = req_valid && req_ready;
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);

    msi_entry_table #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .CFG_W(CFG_W),
        .CNT_W(CNT_W), .IRQ_W(IRQ_W)
    ) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (scan_idx),
        .rd_cfg (ent_cfg),
        .rd_cnt (ent_cnt),
        .rd_base(ent_base),
        .wr_en  (fin_write),
        .wr_idx (scan_idx),
        .wr_cfg (cfg_q),
        .wr_cnt (count_q),
        .wr_base(pool_base)
    );

    msi_irq_pool #(
        .IRQ_W(IRQ_W), .CNT_W(CNT_W),
        .IRQ_FIRST(IRQ_FIRST), .POOL_SIZE(POOL_SIZE)
    ) pool_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ask_n    (count_q),
        .take     (fin_alloc),
        .fits     (pool_fits),
        .next_base(pool_base)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_query && !func_known(req_func)) state_d = ST_FINISH;
                    else                                     state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (ent_cnt == '0 || ent_cfg == cfg_q || scan_idx == LAST_IDX)
                    state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request capture and scan walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            query_q    <= 1'b0;
            bad_func_q <= 1'b0;
            func_q     <= '0;
            cfg_q      <= '0;
            count_q    <= '0;
            vec_q      <= '0;
            seq_q      <= '0;
            scan_idx   <= '0;
            hit_q      <= 1'b0;
            empty_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        query_q    <= req_query;
                        bad_func_q <= !req_query && !func_known(req_func);
                        func_q     <= req_func;
                        cfg_q      <= req_cfg;
                        count_q    <= req_count;
                        vec_q      <= req_vec;
                        seq_q      <= req_seq;
                        scan_idx   <= '0;
                        hit_q      <= 1'b0;
                        empty_q    <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (ent_cnt == '0)            empty_q  <= 1'b1;
                    else if (ent_cfg == cfg_q)    hit_q    <= 1'b1;
                    else if (scan_idx != LAST_IDX) scan_idx <= scan_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Decision made in FINISH
    always_comb begin
        fin_alloc  = 1'b0;
        fin_write  = 1'b0;
        fin_status = STS_HW_ERR;
        fin_count  = '0;
        fin_seq    = '0;
        fin_type   = '0;
        fin_addr   = '0;
        fin_irq    = '0;
        fin_edge   = 1'b0;
        if (state_q == ST_FINISH) begin
            if (bad_func_q) begin
                fin_status = STS_PARAM_ERR;
            end else if (query_q) begin
                if (hit_q) begin
                    fin_status = STS_OK;
                    fin_irq    = ent_base + IRQ_W'(vec_q);
                    fin_edge   = 1'b1;
                end
            end else if (count_q == '0) begin
                if (hit_q) fin_status = STS_OK;
            end else if (hit_q || empty_q) begin
                if (empty_q) begin
                    fin_alloc = 1'b1;
                    fin_write = pool_fits;
                end
                if ((hit_q && ent_cnt == count_q) || (empty_q && pool_fits)) begin
                    fin_status = STS_OK;
                    fin_count  = count_q;
                    fin_seq    = seq_q + 1'b1;
                    fin_type   = (func_q == FN_MSIX) ? TYPE_MSIX : TYPE_MSI;
                    fin_addr   = WIN_BASE | (ADDR_W'(scan_idx) << 16);
                end
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_status   <= STS_OK;
            rsp_count    <= '0;
            rsp_seq      <= '0;
            rsp_type     <= '0;
            rsp_msg_addr <= '0;
            rsp_irq      <= '0;
            rsp_edge     <= 1'b0;
        end else if (state_q == ST_FINISH) begin
            rsp_status   <= fin_status;
            rsp_count    <= fin_count;
            rsp_seq      <= fin_seq;
            rsp_type     <= fin_type;
            rsp_msg_addr <= fin_addr;
            rsp_irq      <= fin_irq;
            rsp_edge     <= fin_edge;
        end
    end

endmodule

// File: rtl/msi_vec_alloc_chk.sv
module msi_vec_alloc_chk #(
    parameter int              DEPTH  = 8,
    parameter int              CNT_W  = 6,
    parameter int              SEQ_W  = 8,
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_query,
    input logic [3:0]        req_func,
    input logic [CNT_W-1:0]  req_count,
    input logic [SEQ_W-1:0]  req_seq,
    input logic              rsp_valid,
    input logic [3:0]        rsp_status,
    input logic [CNT_W-1:0]  rsp_count,
    input logic [SEQ_W-1:0]  rsp_seq,
    input logic [1:0]        rsp_type,
    input logic [ADDR_W-1:0] rsp_msg_addr,
    input logic              rsp_edge
);
    localparam int BW = $clog2(DEPTH + 8) + 1;

    logic             c_query;
    logic [3:0]       c_func;
    logic [CNT_W-1:0] c_count;
    logic [SEQ_W-1:0] c_seq;
    logic [BW-1:0]    busy_cnt;
    logic             c_bad, ok_change;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_query  <= 1'b0;
            c_func   <= 4'd1;
            c_count  <= '0;
            c_seq    <= '0;
            busy_cnt <= '0;
        end else begin
            if (req_valid && req_ready) begin
                c_query <= req_query;
                c_func  <= req_func;
                c_count <= req_count;
                c_seq   <= req_seq;
            end
            if (req_ready)                       busy_cnt <= '0;
            else if (busy_cnt != {BW{1'b1}})     busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assign c_bad     = !c_query && !(c_func == 4'd1 || c_func == 4'd3 || c_func == 4'd4);
    assign ok_change = rsp_valid && !c_query && rsp_status == 4'h0 && c_count != '0;

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_NOT_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R1
    AST_BAD_FUNC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_bad) |-> rsp_status == 4'hD); // R2
    AST_TYPE_FROM_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        ok_change |-> rsp_type == ((c_func == 4'd4) ? 2'd2 : 2'd1)); // R2
    AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ok_change |-> rsp_seq == SEQ_W'(c_seq + 1'b1)); // R3
    AST_RELEASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !c_query && c_count == '0 && rsp_status == 4'h0) |-> rsp_count == '0); // R6
    AST_MSG_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ok_change |-> rsp_msg_addr[15:0] == WIN_BASE[15:0]); // R7
    AST_EDGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_query) |-> rsp_edge == (rsp_status == 4'h0)); // R8
    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BW'(DEPTH + 2)); // R11

endmodule

bind msi_vec_alloc msi_vec_alloc_chk #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .SEQ_W(SEQ_W),
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_query(req_query), .req_func(req_func), .req_count(req_count),
    .req_seq(req_seq), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_count(rsp_count), .rsp_seq(rsp_seq), .rsp_type(rsp_type),
    .rsp_msg_addr(rsp_msg_addr), .rsp_edge(rsp_edge)
);

// File: tb/msi_vec_alloc_tb_top.sv
module msi_vec_alloc_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_query = 1'b0;
    logic [3:0]  req_func = '0;
    logic [15:0] req_cfg = '0;
    logic [5:0]  req_count = '0;
    logic [7:0]  req_seq = '0;
    logic [5:0]  req_vec = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_status;
    logic [5:0]  rsp_count;
    logic [7:0]  rsp_seq;
    logic [1:0]  rsp_type;
    logic [31:0] rsp_msg_addr;
    logic [11:0] rsp_irq;
    logic        rsp_edge;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [3:0]  r_status;
    logic [5:0]  r_count;
    logic [7:0]  r_seq;
    logic [1:0]  r_type;
    logic [31:0] r_addr;
    logic [11:0] r_irq;
    logic        r_edge;

    always #10 clk = ~clk;

    msi_vec_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_query(req_query), .req_func(req_func), .req_cfg(req_cfg),
        .req_count(req_count), .req_seq(req_seq), .req_vec(req_vec),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_count(rsp_count),
        .rsp_seq(rsp_seq), .rsp_type(rsp_type), .rsp_msg_addr(rsp_msg_addr),
        .rsp_irq(rsp_irq), .rsp_edge(rsp_edge)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input bit q, input logic [3:0] f, input logic [15:0] cfg,
                          input logic [5:0] cnt, input logic [7:0] seq, input logic [5:0] vec);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_query = q; req_func = f; req_cfg = cfg;
        req_count = cnt; req_seq = seq; req_vec = vec;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check(rsp_valid && lat <= DEPTH + 3, "R11 latency", lat, DEPTH + 3);
        r_status = rsp_status; r_count = rsp_count; r_seq = rsp_seq; r_type = rsp_type;
        r_addr = rsp_msg_addr; r_irq = rsp_irq; r_edge = rsp_edge;
        check(!req_ready, "R1 busy during response", req_ready, 0);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R1 single pulse", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        apply_reset();
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset state", {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic t_bad_func();
        do_req(0, 4'd2, 16'h0100, 6'd4, 8'd1, 6'd0);
        check(r_status == 4'hD, "R2 func 2 rejected", r_status, 4'hD);
        do_req(0, 4'd0, 16'h0100, 6'd0, 8'd1, 6'd0);
        check(r_status == 4'hD, "R2 func 0 rejected", r_status, 4'hD);
        do_req(1, 4'd0, 16'h0100, 6'd0, 8'd0, 6'd0);
        check(r_status == 4'hF && r_edge == 0, "R2 R8 no entry after bad func", {r_status, r_edge}, 5'h1E);
    endtask

    task automatic t_alloc();
        do_req(0, 4'd3, 16'h0100, 6'd4, 8'd7, 6'd0);
        check(r_status == 4'h0 && r_count == 4 && r_seq == 8 && r_type == 1, "R3 first grant",
              {r_status, r_count, r_seq, r_type}, {4'h0, 6'd4, 8'd8, 2'd1});
        check(r_addr == 32'h4000_0000, "R7 index 0 address", r_addr, 32'h4000_0000);
        do_req(1, 4'd0, 16'h0100, 6'd0, 8'd0, 6'd2);
        check(r_status == 0 && r_irq == 258 && r_edge == 1, "R8 query vec 2", r_irq, 258);
        do_req(0, 4'd4, 16'h0200, 6'd8, 8'd255, 6'd0);
        check(r_status == 0 && r_seq == 8'd0 && r_type == 2, "R3 R2 seq wrap msix", {r_seq, r_type}, {8'd0, 2'd2});
        check(r_addr == 32'h4001_0000, "R7 index 1 address", r_addr, 32'h4001_0000);
        do_req(1, 4'd0, 16'h0200, 6'd0, 8'd0, 6'd7);
        check(r_irq == 267, "R9 contiguous base", r_irq, 267);
    endtask

    task automatic t_reuse();
        do_req(0, 4'd1, 16'h0100, 6'd4, 8'd20, 6'd0);
        check(r_status == 0 && r_addr == 32'h4000_0000 && r_seq == 21, "R4 reuse same count",
              {r_status, r_addr}, {4'h0, 32'h4000_0000});
        do_req(0, 4'd1, 16'h0100, 6'd2, 8'd0, 6'd0);
        check(r_status == 4'hF, "R5 count mismatch", r_status, 4'hF);
        do_req(1, 4'd0, 16'h0100, 6'd0, 8'd0, 6'd3);
        check(r_status == 0 && r_irq == 259, "R5 entry unchanged", r_irq, 259);
    endtask

    task automatic t_release();
        do_req(0, 4'd1, 16'h0100, 6'd0, 8'd9, 6'd0);
        check(r_status == 0 && r_count == 0, "R6 release existing", {r_status, r_count}, 0);
        do_req(0, 4'd1, 16'h0999, 6'd0, 8'd9, 6'd0);
        check(r_status == 4'hF, "R6 release unknown", r_status, 4'hF);
        do_req(1, 4'd0, 16'h0100, 6'd0, 8'd0, 6'd0);
        check(r_status == 0 && r_irq == 256, "R6 entry kept after release", r_irq, 256);
        do_req(1, 4'd0, 16'h0555, 6'd0, 8'd0, 6'd1);
        check(r_status == 4'hF && r_edge == 0, "R8 query unknown", {r_status, r_edge}, 5'h1E);
    endtask

    task automatic t_pool();
        do_req(0, 4'd3, 16'h0300, 6'd32, 8'd0, 6'd0);
        check(r_status == 0 && r_addr == 32'h4002_0000, "R9 R4 grant after reuse", r_addr, 32'h4002_0000);
        do_req(1, 4'd0, 16'h0300, 6'd0, 8'd0, 6'd0);
        check(r_irq == 268, "R4 R9 no pool use on reuse", r_irq, 268);
        do_req(0, 4'd3, 16'h0400, 6'd21, 8'd0, 6'd0);
        check(r_status == 4'hF, "R9 pool overflow by one", r_status, 4'hF);
        do_req(0, 4'd3, 16'h0400, 6'd20, 8'd0, 6'd0);
        check(r_status == 0 && r_addr == 32'h4003_0000, "R9 exact fit takes index 3", r_addr, 32'h4003_0000);
        do_req(1, 4'd0, 16'h0400, 6'd0, 8'd0, 6'd19);
        check(r_irq == 319, "R9 last pool number", r_irq, 319);
        do_req(0, 4'd3, 16'h0500, 6'd1, 8'd0, 6'd0);
        check(r_status == 4'hF, "R9 pool exhausted", r_status, 4'hF);
    endtask

    task automatic t_full();
        apply_reset();
        for (int i = 0; i < DEPTH; i++) begin
            do_req(0, 4'd3, 16'h0010 + 16'(i), 6'd1, 8'd0, 6'd0);
            check(r_status == 0 && r_addr == (32'h4000_0000 | (32'(i) << 16)), "R7 fill address",
                  r_addr, 32'h4000_0000 | (32'(i) << 16));
        end
        do_req(0, 4'd3, 16'h0020, 6'd1, 8'd0, 6'd0);
        check(r_status == 4'hF, "R10 table full", r_status, 4'hF);
        do_req(1, 4'd0, 16'h0017, 6'd0, 8'd0, 6'd0);
        check(r_status == 0 && r_irq == 263, "R10 last entry query", r_irq, 263);
        do_req(0, 4'd1, 16'h0017, 6'd1, 8'd3, 6'd0);
        check(r_status == 0 && r_addr == 32'h4007_0000, "R10 R4 reuse last entry", r_addr, 32'h4007_0000);
    endtask

    initial begin
        t_reset();
        t_bad_func();
        t_alloc();
        t_reuse();
        t_release();
        t_pool();
        t_full();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule